// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block is an 18-bit first-in first-out buffer whose write side and read side run on separate clocks. The clocks may be independent or tied together. Each side keeps a binary pointer. Each pointer is also kept in Gray code and passed to the other side through a chain of synchronizer flops. Every occupancy flag is computed in the domain where it is used. A flag can therefore go active on the same edge as the local access that causes it. When the flag depends on the other side's activity, it clears only after that activity has come through the synchronizers.

The block provides an empty flag, a full flag, a half-full flag and two programmable thresholds: almost-empty and almost-full. Both threshold registers reset to 127. They can be reloaded from the data input by writes that carry a load strobe. A rewind input returns the read side to the first physical location, so that a stored burst can be read again. A mode input decides how the two threshold flags are presented. In registered mode, each flag passes through one flop in its own clock domain. In direct mode, each flag follows the occupancy count combinationally. An output-enable input qualifies the read data.

Top module: `dcf_fifo`

## Requirements
- R1: A word is stored on each rising `wr_clk` edge where `wr_en` is 1, `load_off` is 0 and the buffer is not full. Words leave in the order they were stored.
- R2: On a rising `rd_clk` edge where `rd_en` is 1, `retx` is 0 and `empty_n` is 1, the oldest word is loaded into the output register. After `empty_n` rises, the first stored word appears following the next such read edge.
- R3: `full_n` is 0 exactly when DEPTH words are held. A write attempted while full is dropped, and no stored word changes.
- R4: `empty_n` is 0 when no word is held. A read attempted while empty leaves the read position and the output register unchanged.
- R5: `half_full` is 1 when the write side sees more than DEPTH/2 words held. It is 0 otherwise.
- R6: `ae_n` is 0 when the read side sees a count of words held that is at or below the empty offset. The empty offset resets to 127.
- R7: `af_n` is 0 when the write side sees a count of words held that is at or above DEPTH minus the full offset. The full offset resets to 127.
- R8: A write edge with both `wr_en` and `load_off` at 1 stores nothing in the buffer. Instead it copies `wr_data[ADDR_W-1:0]` into an offset register. After reset, the first such write loads the empty offset, the next loads the full offset, and later ones keep alternating.
- R9: With `sync_mode` at 1, `af_n` is registered on `wr_clk` and `ae_n` is registered on `rd_clk`, so each flag lags its count by one edge of its own clock. With `sync_mode` at 0, both flags follow the counts with no extra register.
- R10: A `retx` pulse, sampled on a rising `rd_clk` edge while `rd_en` is 0, moves the read position to physical location 0. The words stored since reset are then read again from the first one.
- R11: While `oe_n` is 1, `rd_valid` is 0 and `rd_data` is zero. While `oe_n` is 0, `rd_valid` is 1 and `rd_data` shows the output register.
- R12: After reset (`rst_n` at 0), `empty_n`=0, `full_n`=1, `half_full`=0, `ae_n`=0 and `af_n`=1, and the output register holds zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sync_mode | input | 1 | 1: threshold flags registered; 0: threshold flags direct |
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write enable |
| load_off | input | 1 | Redirects a write into the offset registers |
| wr_data | input | DATA_W (18) | Write data or offset value |
| full_n | output | 1 | Low when full (write domain) |
| half_full | output | 1 | High when more than half full (write domain) |
| af_n | output | 1 | Low when almost full (write domain) |
| rd_clk | input | 1 | Read clock |
| rd_en | input | 1 | Read enable |
| retx | input | 1 | Rewind read side to location 0 |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | DATA_W (18) | Read data, zero while not enabled |
| rd_valid | output | 1 | Qualifies rd_data |
| empty_n | output | 1 | Low when empty (read domain) |
| ae_n | output | 1 | Low when almost empty (read domain) |

## Verification
Several properties are checked on every clock edge. A write attempt while full must not move the write pointer. A read attempt while empty must not move the read pointer. The write pointer's Gray code changes at most one bit per edge. Full implies half full. A rewind lands on location zero. In direct mode, empty implies almost empty. Other behaviour can be shown only by the directed scenarios: the data order, the threshold crossings under default and loaded offsets, the one-edge lag of registered mode, the replay after a rewind, and output masking.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   // which offset register the next load-strobed write targets
   typedef enum logic {
      SEL_EMPTY_OFF = 1'b0,
      SEL_FULL_OFF  = 1'b1
   } off_sel_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
   parameter int DW = 18,
   parameter int AW = 8
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rd_clk,
   input  logic          rd_rst_n,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] q
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n)  q <= '0;
      else if (re)    q <= mem[raddr];
   end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
   parameter int AW          = 8,
   parameter int OFF_DEFAULT = 127
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_mode,
   input  logic          wr_en,
   input  logic          load_off,
   input  logic [AW-1:0] ld_val,
   input  logic [AW:0]   rgray_s,
   output logic [AW:0]   wptr_bin,
   output logic [AW:0]   wptr_gray,
   output logic          we,
   output logic [AW-1:0] ae_off,
   output logic          full_n,
   output logic          half_full,
   output logic          af_n
);
   import dcf_pkg::*;

   localparam logic [AW:0] DEPTH_C = {1'b1, {AW{1'b0}}};
   localparam logic [AW:0] HALF_C  = DEPTH_C >> 1;

   function automatic logic [AW:0] from_gray(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [AW:0]   rbin, wcount, wptr_nxt, af_thr;
   logic [AW-1:0] af_off;
   off_sel_e      ld_sel;
   logic          is_full, do_ld, af_hit, af_q;

   assign rbin     = from_gray(rgray_s);
   assign wcount   = wptr_bin - rbin;
   assign is_full  = (wcount == DEPTH_C);
   assign we       = wr_en & ~load_off & ~is_full;
   assign do_ld    = wr_en & load_off;
   assign wptr_nxt = wptr_bin + {{AW{1'b0}}, we};
   assign af_thr   = DEPTH_C - {1'b0, af_off};
   assign af_hit   = (wcount >= af_thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_bin  <= '0;
         wptr_gray <= '0;
         af_q      <= 1'b1;
      end else begin
         wptr_bin  <= wptr_nxt;
         wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
         af_q      <= ~af_hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ae_off <= AW'(OFF_DEFAULT);
         af_off <= AW'(OFF_DEFAULT);
         ld_sel <= SEL_EMPTY_OFF;
      end else if (do_ld) begin
         if (ld_sel == SEL_EMPTY_OFF) ae_off <= ld_val;
         else                         af_off <= ld_val;
         ld_sel <= (ld_sel == SEL_EMPTY_OFF) ? SEL_FULL_OFF : SEL_EMPTY_OFF;
      end
   end

   assign full_n    = ~is_full;
   assign half_full = (wcount > HALF_C);
   assign af_n      = sync_mode ? af_q : ~af_hit;

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !load_off && !full_n) |=> $stable(wptr_bin));

   p_gray_one_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

   p_full_is_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> half_full);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_mode,
   input  logic          rd_en,
   input  logic          retx,
   input  logic [AW:0]   wgray_s,
   input  logic [AW-1:0] ae_off,
   output logic [AW:0]   rptr_bin,
   output logic [AW:0]   rptr_gray,
   output logic          re,
   output logic          empty_n,
   output logic          ae_n
);
   function automatic logic [AW:0] from_gray(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [AW:0] wbin, rcount, rptr_nxt;
   logic        is_empty, ae_hit, ae_q;

   assign wbin     = from_gray(wgray_s);
   assign rcount   = wbin - rptr_bin;
   assign is_empty = (rcount == '0);
   assign re       = rd_en & ~retx & ~is_empty;
   assign rptr_nxt = retx ? '0 : rptr_bin + {{AW{1'b0}}, re};
   assign ae_hit   = (rcount <= {1'b0, ae_off});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_bin  <= '0;
         rptr_gray <= '0;
         ae_q      <= 1'b0;
      end else begin
         rptr_bin  <= rptr_nxt;
         rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
         ae_q      <= ~ae_hit;
      end
   end

   assign empty_n = ~is_empty;
   assign ae_n    = sync_mode ? ae_q : ~ae_hit;

   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !retx && !empty_n) |=> $stable(rptr_bin));

   p_rewind_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
      retx |=> (rptr_bin == '0));

   p_empty_is_almost_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_mode && !empty_n) |-> !ae_n);
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
   parameter int DATA_W      = 18,
   parameter int ADDR_W      = 8,
   parameter int OFF_DEFAULT = 127,
   parameter int SYNC_STAGES = 2
) (
   input  logic              rst_n,
   input  logic              sync_mode,
   input  logic              wr_clk,
   input  logic              wr_en,
   input  logic              load_off,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full_n,
   output logic              half_full,
   output logic              af_n,
   input  logic              rd_clk,
   input  logic              rd_en,
   input  logic              retx,
   input  logic              oe_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              empty_n,
   output logic              ae_n
);
   localparam int PW = ADDR_W + 1;

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
      $error("dcf_fifo: ADDR_W out of range");
   end
   if (OFF_DEFAULT < 0 || OFF_DEFAULT >= (1 << ADDR_W)) begin : g_bad_off
      $error("dcf_fifo: OFF_DEFAULT must be below the depth");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dcf_fifo: SYNC_STAGES must be at least 2");
   end
   if (DATA_W < ADDR_W) begin : g_bad_dw
      $error("dcf_fifo: DATA_W must cover an offset value");
   end

   logic [PW-1:0]     wptr_bin, wptr_gray, rptr_bin, rptr_gray;
   logic [PW-1:0]     wgray_s, rgray_s;
   logic [ADDR_W-1:0] ae_off;
   logic [DATA_W-1:0] ram_q;
   logic              we, re;

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rst_n), .d(wptr_gray), .q(wgray_s));

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(rst_n), .d(rptr_gray), .q(rgray_s));

   dcf_wr_side #(.AW(ADDR_W), .OFF_DEFAULT(OFF_DEFAULT)) u_wr (
      .clk(wr_clk), .rst_n(rst_n), .sync_mode(sync_mode),
      .wr_en(wr_en), .load_off(load_off), .ld_val(wr_data[ADDR_W-1:0]),
      .rgray_s(rgray_s), .wptr_bin(wptr_bin), .wptr_gray(wptr_gray),
      .we(we), .ae_off(ae_off), .full_n(full_n), .half_full(half_full),
      .af_n(af_n));

   dcf_rd_side #(.AW(ADDR_W)) u_rd (
      .clk(rd_clk), .rst_n(rst_n), .sync_mode(sync_mode),
      .rd_en(rd_en), .retx(retx), .wgray_s(wgray_s), .ae_off(ae_off),
      .rptr_bin(rptr_bin), .rptr_gray(rptr_gray), .re(re),
      .empty_n(empty_n), .ae_n(ae_n));

   dcf_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
      .wr_clk(wr_clk), .we(we), .waddr(wptr_bin[ADDR_W-1:0]),
      .wdata(wr_data), .rd_clk(rd_clk), .rd_rst_n(rst_n), .re(re),
      .raddr(rptr_bin[ADDR_W-1:0]), .q(ram_q));

   assign rd_valid = ~oe_n;
   assign rd_data  = oe_n ? '0 : ram_q;
endmodule

// File: tb/sim_dcf_fifo.sv
module sim_dcf_fifo;
   localparam int CLK_PERIOD = 10;
   localparam int RD_PERIOD  = CLK_PERIOD + 4;
   localparam int DW    = 18;
   localparam int AW    = 8;
   localparam int DEPTH = 1 << AW;

   logic rst_n = 1'b0, sync_mode = 1'b0;
   logic wr_clk = 1'b0, wr_en = 1'b0, load_off = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic rd_clk = 1'b0, rd_en = 1'b0, retx = 1'b0, oe_n = 1'b0;
   logic full_n, half_full, af_n, rd_valid, empty_n, ae_n;
   logic [DW-1:0] rd_data;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
   always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

   dcf_fifo u0 (
      .rst_n(rst_n), .sync_mode(sync_mode), .wr_clk(wr_clk), .wr_en(wr_en),
      .load_off(load_off), .wr_data(wr_data), .full_n(full_n),
      .half_full(half_full), .af_n(af_n), .rd_clk(rd_clk), .rd_en(rd_en),
      .retx(retx), .oe_n(oe_n), .rd_data(rd_data), .rd_valid(rd_valid),
      .empty_n(empty_n), .ae_n(ae_n));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic restart(input logic mode);
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; load_off = 1'b0; retx = 1'b0;
      sync_mode = mode;
      repeat (3) @(negedge rd_clk);
      rst_n = 1'b1;
      repeat (2) @(negedge wr_clk);
   endtask

   task automatic settle();
      repeat (4) @(negedge rd_clk);
      repeat (4) @(negedge wr_clk);
   endtask

   task automatic push(input logic [DW-1:0] d);
      @(negedge wr_clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge wr_clk);
      wr_en = 1'b0;
   endtask

   task automatic load(input logic [DW-1:0] d);
      @(negedge wr_clk);
      wr_en = 1'b1; load_off = 1'b1; wr_data = d;
      @(negedge wr_clk);
      wr_en = 1'b0; load_off = 1'b0;
   endtask

   task automatic pop(output logic [DW-1:0] d);
      @(negedge rd_clk);
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic t_reset_state();
      restart(1'b0);
      chk(empty_n == 1'b0, "R12 empty_n", int'(empty_n), 0);
      chk(full_n == 1'b1, "R12 full_n", int'(full_n), 1);
      chk(half_full == 1'b0, "R12 half_full", int'(half_full), 0);
      chk(ae_n == 1'b0, "R12 ae_n", int'(ae_n), 0);
      chk(af_n == 1'b1, "R12 af_n", int'(af_n), 1);
      chk(rd_data == '0, "R12 rd_data", int'(rd_data), 0);
   endtask

   task automatic t_fill_drain();
      logic [DW-1:0] d;
      int bad_order;
      restart(1'b0);
      for (int i = 0; i < 127; i++) push(DW'(i));
      settle();
      chk(ae_n == 1'b0, "R6 ae at 127", int'(ae_n), 0);
      push(DW'(127));
      settle();
      chk(ae_n == 1'b1, "R6 ae at 128", int'(ae_n), 1);
      chk(half_full == 1'b0, "R5 half at 128", int'(half_full), 0);
      chk(af_n == 1'b1, "R7 af at 128", int'(af_n), 1);
      push(DW'(128));
      chk(half_full == 1'b1, "R5 half at 129", int'(half_full), 1);
      chk(af_n == 1'b0, "R7 af at 129", int'(af_n), 0);
      for (int i = 129; i < DEPTH; i++) push(DW'(i));
      chk(full_n == 1'b0, "R3 full at depth", int'(full_n), 0);
      push(DW'('h3FFFF));
      chk(full_n == 1'b0, "R3 still full", int'(full_n), 0);
      settle();
      chk(empty_n == 1'b1, "R2 not empty", int'(empty_n), 1);
      bad_order = 0;
      for (int i = 0; i < DEPTH; i++) begin
         pop(d);
         if (d != DW'(i)) bad_order++;
      end
      chk(bad_order == 0, "R1 order and R3 dropped word", bad_order, 0);
      chk(empty_n == 1'b0, "R4 empty after drain", int'(empty_n), 0);
      pop(d);
      chk(d == DW'(DEPTH - 1), "R4 read while empty", int'(d), DEPTH - 1);
      push(DW'('h123));
      settle();
      pop(d);
      chk(d == DW'('h123), "R2 R4 next word after empty", int'(d), 'h123);
   endtask

   task automatic t_offsets();
      restart(1'b0);
      load(DW'(4));
      load(DW'(8));
      settle();
      chk(empty_n == 1'b0, "R8 load stores nothing", int'(empty_n), 0);
      for (int i = 0; i < 4; i++) push(DW'(i));
      settle();
      chk(ae_n == 1'b0, "R8 R6 ae at 4", int'(ae_n), 0);
      push(DW'(4));
      settle();
      chk(ae_n == 1'b1, "R8 R6 ae at 5", int'(ae_n), 1);
      for (int i = 5; i < DEPTH - 9; i++) push(DW'(i));
      chk(af_n == 1'b1, "R8 R7 af at 247", int'(af_n), 1);
      push(DW'(0));
      chk(af_n == 1'b0, "R8 R7 af at 248", int'(af_n), 0);
   endtask

   task automatic t_flag_mode();
      restart(1'b0);
      for (int i = 0; i < 128; i++) push(DW'(i));
      settle();
      @(negedge wr_clk); wr_en = 1'b1;
      @(negedge wr_clk); wr_en = 1'b0;
      chk(af_n == 1'b0, "R9 direct af immediate", int'(af_n), 0);
      restart(1'b1);
      for (int i = 0; i < 128; i++) push(DW'(i));
      settle();
      @(negedge wr_clk); wr_en = 1'b1;
      @(negedge wr_clk); wr_en = 1'b0;
      chk(af_n == 1'b1, "R9 registered af lags", int'(af_n), 1);
      @(negedge wr_clk);
      chk(af_n == 1'b0, "R9 registered af next edge", int'(af_n), 0);
   endtask

   task automatic t_rewind();
      logic [DW-1:0] d;
      int bad;
      restart(1'b0);
      for (int i = 0; i < 5; i++) push(DW'('hA0 + i));
      settle();
      for (int i = 0; i < 5; i++) pop(d);
      settle();
      chk(empty_n == 1'b0, "R10 empty before rewind", int'(empty_n), 0);
      @(negedge rd_clk); retx = 1'b1;
      @(negedge rd_clk); retx = 1'b0;
      settle();
      chk(empty_n == 1'b1, "R10 data after rewind", int'(empty_n), 1);
      bad = 0;
      for (int i = 0; i < 5; i++) begin
         pop(d);
         if (d != DW'('hA0 + i)) bad++;
      end
      chk(bad == 0, "R10 replay order", bad, 0);
   endtask

   task automatic t_output_enable();
      logic [DW-1:0] d;
      restart(1'b0);
      push(DW'('h2BEEF));
      settle();
      oe_n = 1'b1;
      pop(d);
      chk(d == '0, "R11 data masked", int'(d), 0);
      chk(rd_valid == 1'b0, "R11 valid low", int'(rd_valid), 0);
      oe_n = 1'b0;
      #1;
      chk(rd_data == DW'('h2BEEF), "R11 data shown", int'(rd_data), 'h2BEEF);
      chk(rd_valid == 1'b1, "R11 valid high", int'(rd_valid), 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset_state();
      t_fill_drain();
      t_offsets();
      t_flag_mode();
      t_rewind();
      t_output_enable();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule